// File: doc/BRIEF.md
# Debounced Pushbutton Single-Pulse Generator

This block turns a raw mechanical pushbutton into one clean pulse of fixed width for every press. The button input is active-low (0 means pressed) and asynchronous to the system clock. It first passes through a chain of synchronizer flops. A debouncer then accepts a level change only after the synchronized input has held the new level for a full debounce interval, so contact chatter never reaches the pulse logic. Each accepted press starts a timer that holds the true output high for exactly the configured number of clock cycles. A complemented output is driven at all times.

Both time intervals are given in milliseconds together with the clock frequency, and are converted to cycle counts when the design is built. At the default 25.175 MHz clock a 20 ms pulse lasts 503,500 cycles and a 5 ms debounce lasts 125,875 cycles. Downstream logic should use the pulse as a clock enable or a step request, never as a clock. Holding the button produces a single pulse. A press that is accepted while a pulse is still running is dropped: it is not queued, and it neither stretches nor restarts the pulse.

Top module: `btn_pulse_gen`

## Requirements
- R1: After reset `pulse` is 0. It goes to 1 only in response to an accepted press.
- R2: Every pulse stays at 1 for exactly PW = CLK_HZ*PULSE_MS/1000 clock cycles and then returns to 0.
- R3: `pulse_n` is the logical complement of `pulse` in every cycle.
- R4: Chatter, meaning input changes that last fewer than DB = CLK_HZ*DEBOUNCE_MS/1000 cycles, never produces a pulse. A bouncing press followed by a stable hold produces exactly one pulse.
- R5: A press is accepted once the synchronized input has been 0 for DB consecutive cycles. With SYNC_STAGES=2, `pulse` first reads 1 after DB+3 rising clock edges, counted from the first edge that samples `btn_n`=0. A low shorter than DB cycles is ignored.
- R6: `btn_n` is active-low: 0 means pressed and 1 means released. A release never starts a pulse.
- R7: Holding the button for longer than a pulse gives one pulse only. A further pulse needs a debounced release followed by a new debounced press.
- R8: A press accepted while a pulse is in progress is ignored. The running pulse keeps its width of PW cycles, and no second pulse follows.
- R9: Synchronous reset `rst` clears the pulse, the timers and the press tracking. `pulse` is 0 in the cycle after `rst` is sampled high, and no pulse appears afterwards unless there is a new press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Raw pushbutton, asynchronous, 0 = pressed |
| pulse | output | 1 | Fixed-width pulse, one per accepted press |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The hardest situation to reach from the ports is a press that the debouncer accepts while a pulse is still running. Reaching it takes three steps inside one pulse window: a press, then a release that is held long enough to be debounced, then a second press that is held for the full debounce interval. The bench uses short cycle counts (debounce 10 cycles, pulse 40 cycles) so that this sequence fits inside one pulse. It then checks that the width stays exactly 40 cycles and that only one rising edge occurs. Chatter is produced with toggle runs shorter than the debounce interval, on both the press and the release.

// File: rtl/btn_pulse_pkg.sv
package btn_pulse_pkg;
   // Converts a time in milliseconds to a number of clock cycles.
   function automatic int unsigned ms_to_cycles(input longint unsigned hz, input longint unsigned ms);
      longint unsigned prod;
      prod = (hz * ms) / 64'd1000;
      return int'(prod);
   endfunction

   typedef logic [1:0] sync_level_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("btn_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b1;
               else     chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b1;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
   parameter int DB_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic level_in,
   output logic level_out,
   output logic press_evt
);
   localparam int CW = (DB_CYC < 2) ? 1 : $clog2(DB_CYC);

   generate
      if (DB_CYC < 1) begin : g_bad_db
         $error("btn_debounce: DB_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run;
   logic          differ;
   logic          settle;

   assign differ = (level_in != level_out);
   assign settle = differ && (run == CW'(DB_CYC - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         level_out <= 1'b0;
         run       <= '0;
         press_evt <= 1'b0;
      end else begin
         press_evt <= settle && level_in;
         if (!differ) begin
            run <= '0;
         end else if (settle) begin
            level_out <= level_in;
            run       <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end
endmodule

// File: rtl/btn_pulse_timer.sv
module btn_pulse_timer #(
   parameter int PW_CYC = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(PW_CYC);

   generate
      if (PW_CYC < 2) begin : g_bad_pw
         $error("btn_pulse_timer: PW_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         elapsed <= '0;
      end else if (active) begin
         if (elapsed == CW'(PW_CYC - 1)) begin
            active  <= 1'b0;
            elapsed <= '0;
         end else begin
            elapsed <= elapsed + 1'b1;
         end
      end else if (start) begin
         active  <= 1'b1;
         elapsed <= '0;
      end
   end
endmodule

// File: rtl/btn_pulse_gen.sv
module btn_pulse_gen #(
   parameter longint unsigned CLK_HZ      = 25_175_000,
   parameter int              PULSE_MS    = 20,
   parameter int              DEBOUNCE_MS = 5,
   parameter int              SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_n,
   output logic pulse,
   output logic pulse_n
);
   import btn_pulse_pkg::*;

   localparam int PW_CYC = int'(ms_to_cycles(CLK_HZ, longint'(PULSE_MS)));
   localparam int DB_CYC = int'(ms_to_cycles(CLK_HZ, longint'(DEBOUNCE_MS)));

   generate
      if (DEBOUNCE_MS >= PULSE_MS) begin : g_bad_ratio
         $error("btn_pulse_gen: debounce time must be shorter than the pulse");
      end
   endgenerate

   logic btn_sync_n;
   logic btn_pressed_s;
   logic db_level;
   logic press_evt;
   logic active;

   btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (btn_n),
      .sync_out (btn_sync_n)
   );

   assign btn_pressed_s = ~btn_sync_n;

   btn_debounce #(.DB_CYC(DB_CYC)) u_db (
      .clk       (clk),
      .rst       (rst),
      .level_in  (btn_pressed_s),
      .level_out (db_level),
      .press_evt (press_evt)
   );

   btn_pulse_timer #(.PW_CYC(PW_CYC)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .start  (press_evt),
      .active (active)
   );

   assign pulse   = active;
   assign pulse_n = ~active;
endmodule

// File: rtl/btn_pulse_chk.sv
module btn_pulse_chk #(
   parameter int DB_CYC = 16,
   parameter int PW_CYC = 32
) (
   input logic clk,
   input logic rst,
   input logic pulse,
   input logic pulse_n,
   input logic lvl_in,
   input logic lvl_db,
   input logic evt
);
   int unsigned hi_cnt;
   int unsigned diff_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_cnt   <= 0;
         diff_run <= 0;
      end else begin
         hi_cnt   <= pulse ? hi_cnt + 1 : 0;
         diff_run <= (lvl_in != lvl_db) ? diff_run + 1 : 0;
      end
   end

   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) pulse_n == !pulse); // R3
   AST_EXACT_WIDTH: assert property (@(posedge clk) disable iff (rst) $fell(pulse) |-> hi_cnt == PW_CYC); // R2
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) pulse |-> hi_cnt < PW_CYC); // R2
   AST_RISE_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst) $rose(pulse) |-> $past(evt)); // R1
   AST_SETTLED_CHANGE: assert property (@(posedge clk) disable iff (rst) $changed(lvl_db) |-> $past(diff_run) == DB_CYC - 1); // R4
   AST_EVT_ON_PRESS_ONLY: assert property (@(posedge clk) disable iff (rst) evt |-> lvl_db); // R6
   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !pulse); // R9
endmodule

bind btn_pulse_gen btn_pulse_chk #(.DB_CYC(DB_CYC), .PW_CYC(PW_CYC)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pulse   (pulse),
   .pulse_n (pulse_n),
   .lvl_in  (btn_pressed_s),
   .lvl_db  (db_level),
   .evt     (press_evt)
);

// File: tb/btn_pulse_gen_test.sv
`timescale 1ns/1ps
module btn_pulse_gen_test;
   localparam longint unsigned T_HZ = 2000;
   localparam int T_PULSE_MS = 20;
   localparam int T_DB_MS    = 5;
   localparam int EXP_PW  = 40;   // 2000*20/1000
   localparam int EXP_DB  = 10;   // 2000*5/1000
   localparam int EXP_LAT = EXP_DB + 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn_n = 1'b1;
   logic pulse, pulse_n;

   int checks = 0;
   int fails = 0;
   int rises = 0;
   int cur_w = 0;
   int last_w = 0;
   int comp_err = 0;
   logic prev_p = 1'b0;

   always #2 clk = ~clk;

   btn_pulse_gen #(.CLK_HZ(T_HZ), .PULSE_MS(T_PULSE_MS), .DEBOUNCE_MS(T_DB_MS), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .btn_n(btn_n), .pulse(pulse), .pulse_n(pulse_n)
   );

   always @(negedge clk) begin
      if (pulse_n !== ~pulse) comp_err++;
      if (pulse && !prev_p) rises++;
      if (pulse) cur_w++;
      else if (prev_p) begin last_w = cur_w; cur_w = 0; end
      prev_p = pulse;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      btn_n = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      check("R1 pulse low after reset", int'(pulse), 0);
      check("R3 pulse_n high after reset", int'(pulse_n), 1);
   endtask

   task automatic t_latency_width();
      int r0, n;
      r0 = rises;
      btn_n = 1'b0;
      n = 0;
      while (!pulse && n < 100) begin @(negedge clk); n++; end
      check("R5 press to pulse latency", n, EXP_LAT);
      hold(1'b0, 60);
      hold(1'b1, 40);
      check("R2 pulse width", last_w, EXP_PW);
      check("R7 one pulse while held", rises - r0, 1);
   endtask

   task automatic t_short_press();
      int r0;
      r0 = rises;
      hold(1'b0, EXP_DB - 4);
      hold(1'b1, 40);
      check("R5 short low ignored", rises - r0, 0);
   endtask

   task automatic t_release_only();
      int r0;
      r0 = rises;
      hold(1'b1, 60);
      check("R6 release never pulses", rises - r0, 0);
   endtask

   task automatic t_bounce();
      int r0;
      r0 = rises;
      for (int i = 0; i < 6; i++) begin hold(1'b0, 4); hold(1'b1, 3); end
      check("R4 chatter alone no pulse yet", rises - r0, 0);
      hold(1'b0, 70);
      for (int i = 0; i < 5; i++) begin hold(1'b1, 3); hold(1'b0, 5); end
      hold(1'b1, 40);
      check("R4 bouncy press gives one pulse", rises - r0, 1);
      check("R4 bouncy pulse width", last_w, EXP_PW);
   endtask

   task automatic t_repress();
      int r0;
      r0 = rises;
      hold(1'b0, 60);
      hold(1'b1, 30);
      hold(1'b0, 60);
      hold(1'b1, 30);
      check("R7 release then press gives second pulse", rises - r0, 2);
   endtask

   task automatic t_press_in_pulse();
      int r0;
      r0 = rises;
      hold(1'b0, 16);
      check("R8 pulse running", int'(pulse), 1);
      hold(1'b1, 16);
      hold(1'b0, 20);
      check("R8 pulse still running at second press", int'(pulse), 1);
      hold(1'b1, 80);
      check("R8 second press ignored", rises - r0, 1);
      check("R8 width not stretched", last_w, EXP_PW);
   endtask

   task automatic t_reset_mid();
      int r0;
      hold(1'b0, EXP_LAT + 5);
      check("R9 pulse high before reset", int'(pulse), 1);
      btn_n = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check("R9 pulse cleared by reset", int'(pulse), 0);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      r0 = rises;
      hold(1'b1, 80);
      check("R9 no pulse after reset", rises - r0, 0);
      check("R9 pulse stays low", int'(pulse), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_latency_width();
      t_short_press();
      t_release_only();
      t_bounce();
      t_repress();
      t_press_in_pulse();
      t_reset_mid();
      check("R3 complement every cycle", comp_err, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule